// File: doc/BRIEF.md
# DDR SDRAM Command Decode and Bank Tracker

This block is the device-side command front end of a four-bank double data rate SDRAM. On every rising clock edge it captures chip select, the three command strobes (row strobe, column strobe, write enable), the bank address, the 13-bit address bus and the clock enable. From the captured values it works out which command was issued, keeps a record of which banks hold an open row and which row that is, stores the two mode registers, and tracks whether the device is in precharge or active power-down.

The bank address and address bit 10 change meaning with the command. During a mode register load the bank address picks which of the two registers is written. During a precharge, address bit 10 picks one bank or all of them. During a read or write it requests auto-precharge. When clock enable drops, the live bank state decides which power-down kind is entered. Illegal sequences and a clock enable drop during a data access are reported as single-cycle error pulses.

All effects of a command appear one clock after it is captured, so a command set up before edge k changes the outputs after edge k+1.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: When chip select (active low) is captured high, the command is a deselect: bank state and mode registers do not change, whatever the strobes show.
- R2: Commands are coded as {cs_n, ras_n, cas_n, we_n}: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000, NOP 0111. An ACTIVE to an idle bank opens the bank chosen by `ba` and records `addr` as its row, visible one clock after capture.
- R3: A READ or WRITE to an open bank with `addr[10]`=1 closes that bank one clock after capture. With `addr[10]`=0 the bank stays open with its row unchanged.
- R4: A PRECHARGE with `addr[10]`=0 closes only the bank named by `ba`. With `addr[10]`=1 it closes all four banks. Precharging an idle bank is legal.
- R5: A LOAD MODE with all banks idle stores `addr` into the mode register when `ba`=0 and into the extended mode register when `ba`=1. When `ba[1]`=1 neither register changes.
- R6: A READ or WRITE to an idle bank, an ACTIVE to an open bank, and a REFRESH or LOAD MODE while any bank is open each raise `cmd_err` for exactly one cycle and leave bank state and mode registers unchanged.
- R7: When captured clock enable falls, the block enters precharge power-down (`pd_precharge`) if all banks are idle, otherwise active power-down (`pd_active`). Both clear once clock enable is captured high again.
- R8: A READ or WRITE starts an access window of BURST_CYC cycles. Clock enable captured low inside that window raises `cke_err` for each such cycle.
- R9: While captured clock enable is low, commands are ignored: bank state and mode registers hold.
- R10: Synchronous active-low reset leaves all banks idle, all rows and both mode registers zero, no power-down and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column or op-code; bit 10 is the precharge qualifier |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| open_row | output | 52 | Row of each bank, bank b in bits [13b+12:13b] |
| mode_reg | output | 13 | Mode register contents |
| ext_mode_reg | output | 13 | Extended mode register contents |
| pd_precharge | output | 1 | In precharge power-down |
| pd_active | output | 1 | In active power-down |
| cmd_err | output | 1 | One-cycle pulse on an illegal command |
| cke_err | output | 1 | Pulse when clock enable is low during an access |

## Verification
The hardest case to reach is a clock enable drop inside a data access, because it needs a bank opened, a read issued, and clock enable released on the exact cycle after the access window starts. The same drop must also pick active power-down from the live bank state. The bench gets there by opening a bank, issuing a READ without auto-precharge, and pulling clock enable low on the following negative edge. It then checks both the violation pulse and the power-down kind two edges later. A second path enters power-down with all banks idle and issues an ACTIVE while clock enable is low, to show the command is not taken.

// File: rtl/ddrfe_pkg.sv
// Package: shared parameters and command type for the command tracker.
// Assumes four banks and a 13-bit address bus by default.
package ddrfe_pkg;
    localparam int NUM_BANKS = 4;
    localparam int BA_W      = $clog2(NUM_BANKS);
    localparam int ADDR_W    = 13;
    localparam int AP_BIT    = 10;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } cmd_t;
endpackage

// File: rtl/ddrfe_cmd_decode.sv
// Module: captures the command pins on each rising edge and decodes them.
// Assumes active-low strobes. A command is only reported while the captured
// clock enable is high; otherwise the output is CMD_NOP.
module ddrfe_cmd_decode
    import ddrfe_pkg::*;
#(
    parameter int BAW = BA_W,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cke,
    input  logic           cs_n,
    input  logic           ras_n,
    input  logic           cas_n,
    input  logic           we_n,
    input  logic [BAW-1:0] ba,
    input  logic [AW-1:0]  addr,
    output cmd_t           cmd,
    output logic [BAW-1:0] ba_q,
    output logic [AW-1:0]  addr_q,
    output logic           cke_q,
    output logic           cke_fall,
    output logic           cs_n_q
);
    logic ras_q, cas_q, we_q, cke_qq;

    // Capture pins on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            ras_q  <= 1'b1;
            cas_q  <= 1'b1;
            we_q   <= 1'b1;
            ba_q   <= '0;
            addr_q <= '0;
            cke_q  <= 1'b1;
            cke_qq <= 1'b1;
        end else begin
            cs_n_q <= cs_n;
            ras_q  <= ras_n;
            cas_q  <= cas_n;
            we_q   <= we_n;
            ba_q   <= ba;
            addr_q <= addr;
            cke_q  <= cke;
            cke_qq <= cke_q;
        end
    end

    assign cke_fall = cke_qq && !cke_q;

    // Decode captured strobes; deselect or low clock enable gives NOP.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n_q && cke_q) begin
            unique case ({ras_q, cas_q, we_q})
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                3'b000:  cmd = CMD_LMR;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddrfe_bank_table.sv
// Module: per-bank open/row record and command legality check.
// Assumes cmd is already masked by chip select and clock enable.
// Illegal commands leave the table untouched.
module ddrfe_bank_table
    import ddrfe_pkg::*;
#(
    parameter int NB  = NUM_BANKS,
    parameter int BAW = BA_W,
    parameter int AW  = ADDR_W,
    parameter int APB = AP_BIT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  cmd_t           cmd,
    input  logic [BAW-1:0] ba_q,
    input  logic [AW-1:0]  addr_q,
    output logic [NB-1:0]  bank_open,
    output logic [NB*AW-1:0] open_row,
    output logic           illegal
);
    logic any_open, tgt_open;

    assign any_open = |bank_open;
    assign tgt_open = bank_open[ba_q];

    // Flag commands that conflict with the current bank state.
    always_comb begin
        unique case (cmd)
            CMD_RD, CMD_WR:   illegal = !tgt_open;
            CMD_ACT:          illegal = tgt_open;
            CMD_REF, CMD_LMR: illegal = any_open;
            default:          illegal = 1'b0;
        endcase
    end

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit;
        assign hit = (ba_q == BAW'(b));

        // Open, close or hold this bank's row record.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_open[b]          <= 1'b0;
                open_row[b*AW +: AW]  <= '0;
            end else if (!illegal) begin
                if (cmd == CMD_ACT && hit) begin
                    bank_open[b]         <= 1'b1;
                    open_row[b*AW +: AW] <= addr_q;
                end else if (cmd == CMD_PRE && (hit || addr_q[APB])) begin
                    bank_open[b] <= 1'b0;
                end else if ((cmd == CMD_RD || cmd == CMD_WR) && hit && addr_q[APB]) begin
                    bank_open[b] <= 1'b0;
                end
            end
        end

        AST_AUTO_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd == CMD_RD || cmd == CMD_WR) && hit && bank_open[b] && addr_q[APB])
            |=> !bank_open[b]); // R3
        AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && hit && !bank_open[b]) |=> bank_open[b]); // R2
    end
endmodule

// File: rtl/ddrfe_mode_regs.sv
// Module: holds the mode register and the extended mode register.
// Assumes the write strobe is already qualified by command legality.
module ddrfe_mode_regs
    import ddrfe_pkg::*;
#(
    parameter int BAW = BA_W,
    parameter int AW  = ADDR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [BAW-1:0] ba_q,
    input  logic [AW-1:0]  addr_q,
    output logic [AW-1:0]  mode_reg,
    output logic [AW-1:0]  ext_mode_reg
);
    // Store the op-code into the register the bank address selects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_reg     <= '0;
            ext_mode_reg <= '0;
        end else if (load) begin
            if (ba_q == BAW'(0))      mode_reg     <= addr_q;
            else if (ba_q == BAW'(1)) ext_mode_reg <= addr_q;
        end
    end

    AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(mode_reg) && $stable(ext_mode_reg))); // R5
endmodule

// File: rtl/ddr_cmd_tracker.sv
// Module: top of the command front end. Joins decode, bank table and mode
// registers, and adds power-down tracking, the access window and error pulses.
// Assumes synchronous active-low reset and a single clock.
module ddr_cmd_tracker
    import ddrfe_pkg::*;
#(
    parameter int BURST_CYC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cke,
    input  logic                      cs_n,
    input  logic                      ras_n,
    input  logic                      cas_n,
    input  logic                      we_n,
    input  logic [BA_W-1:0]           ba,
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_BANKS-1:0]      bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] open_row,
    output logic [ADDR_W-1:0]         mode_reg,
    output logic [ADDR_W-1:0]         ext_mode_reg,
    output logic                      pd_precharge,
    output logic                      pd_active,
    output logic                      cmd_err,
    output logic                      cke_err
);
    localparam int CNT_W = $clog2(BURST_CYC + 1);

    cmd_t              cmd;
    logic [BA_W-1:0]   ba_q;
    logic [ADDR_W-1:0] addr_q;
    logic              cke_q, cke_fall, cs_n_q, illegal;
    logic [CNT_W-1:0]  busy_cnt;

    ddrfe_cmd_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd(cmd),
        .ba_q(ba_q), .addr_q(addr_q), .cke_q(cke_q), .cke_fall(cke_fall),
        .cs_n_q(cs_n_q)
    );

    ddrfe_bank_table u_banks (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba_q(ba_q), .addr_q(addr_q),
        .bank_open(bank_open), .open_row(open_row), .illegal(illegal)
    );

    ddrfe_mode_regs u_mode (
        .clk(clk), .rst_n(rst_n), .load(cmd == CMD_LMR && !illegal),
        .ba_q(ba_q), .addr_q(addr_q), .mode_reg(mode_reg),
        .ext_mode_reg(ext_mode_reg)
    );

    // Access window: reload on a legal read or write, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if ((cmd == CMD_RD || cmd == CMD_WR) && !illegal)
            busy_cnt <= CNT_W'(BURST_CYC);
        else if (busy_cnt != '0)
            busy_cnt <= busy_cnt - 1'b1;
    end

    // Register error pulses from the captured command and clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
            cke_err <= 1'b0;
        end else begin
            cmd_err <= illegal;
            cke_err <= !cke_q && (busy_cnt != '0);
        end
    end

    // Select power-down kind on the clock enable fall; leave when it returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_precharge <= 1'b0;
            pd_active    <= 1'b0;
        end else if (cke_q) begin
            pd_precharge <= 1'b0;
            pd_active    <= 1'b0;
        end else if (cke_fall) begin
            pd_precharge <= !(|bank_open);
            pd_active    <= |bank_open;
        end
    end

    AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |=> ($stable(bank_open) && $stable(mode_reg) && $stable(ext_mode_reg))); // R1
    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $stable(bank_open)); // R6
    AST_PD_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_precharge |-> (bank_open == '0)); // R7
    AST_PD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |=> $stable(bank_open)); // R9
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= CNT_W'(BURST_CYC)); // R8
endmodule

// File: tb/ddr_cmd_tracker_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module ddr_cmd_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [12:0] addr = '0;
    logic [3:0]  bank_open;
    logic [51:0] open_row;
    logic [12:0] mode_reg, ext_mode_reg;
    logic        pd_precharge, pd_active, cmd_err, cke_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ddr_cmd_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .bank_open(bank_open), .open_row(open_row), .mode_reg(mode_reg),
        .ext_mode_reg(ext_mode_reg), .pd_precharge(pd_precharge),
        .pd_active(pd_active), .cmd_err(cmd_err), .cke_err(cke_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a code at a negative edge, NOP next; returns after the update edge.
    task automatic issue(input logic [3:0] code, input logic [1:0] b, input logic [12:0] a);
        {cs_n, ras_n, cas_n, we_n} = code;
        ba = b;
        addr = a;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        @(negedge clk);
    endtask

    localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100,
                           C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

    task automatic t_reset();
        check("R10 bank_open", bank_open, 4'b0);
        check("R10 open_row", open_row, 52'b0);
        check("R10 modes", {mode_reg, ext_mode_reg}, 26'b0);
        check("R10 pd/err", {pd_precharge, pd_active, cmd_err, cke_err}, 4'b0);
    endtask

    task automatic t_mode();
        issue(C_LMR, 2'd0, 13'h0123);
        check("R5 mode", mode_reg, 13'h0123);
        issue(C_LMR, 2'd1, 13'h0456);
        check("R5 ext", ext_mode_reg, 13'h0456);
        issue(C_LMR, 2'd2, 13'h1fff);
        check("R5 ba1 ignored", {mode_reg, ext_mode_reg}, {13'h0123, 13'h0456});
    endtask

    task automatic t_deselect();
        issue(4'b1011, 2'd2, 13'h0aaa);
        check("R1 deselect no open", bank_open, 4'b0);
        issue(4'b1000, 2'd0, 13'h0777);
        check("R1 deselect no load", mode_reg, 13'h0123);
    endtask

    task automatic t_activate();
        issue(C_ACT, 2'd1, 13'h1abc);
        check("R2 open b1", bank_open, 4'b0010);
        check("R2 row b1", open_row[13 +: 13], 13'h1abc);
        issue(C_ACT, 2'd3, 13'h0042);
        check("R2 open b3", bank_open, 4'b1010);
        check("R2 row b3", open_row[39 +: 13], 13'h0042);
    endtask

    task automatic t_illegal();
        issue(C_RD, 2'd0, 13'h0);
        check("R6 read idle err", cmd_err, 1'b1);
        @(negedge clk);
        check("R6 one cycle", cmd_err, 1'b0);
        issue(C_ACT, 2'd1, 13'h0555);
        check("R6 act open err", cmd_err, 1'b1);
        check("R6 row kept", open_row[13 +: 13], 13'h1abc);
        issue(C_REF, 2'd0, 13'h0);
        check("R6 refresh open err", cmd_err, 1'b1);
        issue(C_LMR, 2'd0, 13'h0999);
        check("R6 lmr open err", {cmd_err, mode_reg}, {1'b1, 13'h0123});
        check("R6 banks kept", bank_open, 4'b1010);
    endtask

    task automatic t_access();
        issue(C_WR, 2'd1, 13'h0010);
        check("R3 no ap stays", {cmd_err, bank_open}, {1'b0, 4'b1010});
        issue(C_RD, 2'd3, 13'h0400);
        check("R3 ap closes", bank_open, 4'b0010);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_precharge();
        issue(C_ACT, 2'd0, 13'h0001);
        issue(C_ACT, 2'd2, 13'h0002);
        issue(C_PRE, 2'd2, 13'h0000);
        check("R4 single", bank_open, 4'b0011);
        issue(C_PRE, 2'd2, 13'h0000);
        check("R4 idle legal", {cmd_err, bank_open}, {1'b0, 4'b0011});
        issue(C_PRE, 2'd0, 13'h0400);
        check("R4 all", bank_open, 4'b0000);
        issue(C_REF, 2'd0, 13'h0);
        check("R6 refresh idle ok", cmd_err, 1'b0);
    endtask

    task automatic t_pd_pre();
        cke = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 pd precharge", {pd_precharge, pd_active}, 2'b10);
        issue(C_ACT, 2'd0, 13'h0333);
        check("R9 ignored in pd", bank_open, 4'b0);
        cke = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 pd exit", {pd_precharge, pd_active}, 2'b00);
    endtask

    task automatic t_cke_violation();
        issue(C_ACT, 2'd2, 13'h0777);
        check("R8 no err before", cke_err, 1'b0);
        issue(C_RD, 2'd2, 13'h0005);
        cke = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 cke err", cke_err, 1'b1);
        check("R7 pd active", {pd_precharge, pd_active}, 2'b01);
        repeat (6) @(negedge clk);
        check("R8 window over", cke_err, 1'b0);
        cke = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 bank held", bank_open, 4'b0100);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode();
        t_deselect();
        t_activate();
        t_illegal();
        t_access();
        t_precharge();
        t_pd_pre();
        t_cke_violation();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule